// File: doc/BRIEF.md
# Processor Register Bank with Built-In Constant Source

This block holds the sixteen architectural registers of a small 16/20-bit processor core. It has one source read port, one destination read port and one write port. Index 0 is the program counter, index 1 the stack pointer, index 2 the status word and index 3 has no storage at all. Indices 4 to 15 are general registers.

Source reads through index 2 with a nonzero mode, and all source reads through index 3, return a fixed constant chosen by the 2-bit mode field. The core therefore gets the six most common small constants without an extension word and without any memory access. The register width is the parameter `XLEN` (16 or 20). In the wide variant the status word stays 16 bits. Writes are shaped by an operand-size code: byte and word writes clear the bits above them, and address-size writes keep the full width.

The destination index serves as both the destination read address and the write address, so a read-modify-write instruction reads the old value and writes back the result on the same port. Reads are combinational. Writes take effect on the rising clock edge.

Top module: `regbank_cg`

## Requirements
- R1: Synchronous active-high reset clears every register, so afterwards a destination read of any index returns 0.
- R2: A source read of index 2 with mode 00 returns the stored status word, zero-extended to XLEN.
- R3: A source read of index 2 returns 0 for mode 01, 0x4 for mode 10 and 0x8 for mode 11, whatever the status word holds.
- R4: A source read of index 3 returns 0x0 for mode 00, 0x1 for mode 01 and 0x2 for mode 10. For mode 11 with `src_addr`=0 it returns 0xFFFF, zero-extended to XLEN.
- R5: A source read of index 3 with mode 11 and `src_addr`=1 returns all ones across XLEN (0xFFFFF when XLEN=20).
- R6: A source read of any index other than 2 and 3 returns that register's stored value for every mode.
- R7: A write with size code 00 (byte) stores data bits 7:0 and clears all higher bits.
- R8: A write with size code 01 (word), or the reserved code 11, stores data bits 15:0 and clears all higher bits.
- R9: A write with size code 10 (address) stores all XLEN data bits.
- R10: The status word (index 2) is 16 bits wide: an address-size write keeps only bits 15:0, and its upper read bits are always 0.
- R11: Writes to index 3 are ignored. Afterwards its source constants are unchanged and a destination read of index 3 returns 0.
- R12: Bit 0 of the program counter and of the stack pointer is stored as 0 on every write.
- R13: A write lands on the rising edge. A read of the index being written in the same cycle returns the old value, and the new value is readable in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| src_idx | input | 4 | Source register index |
| src_mode | input | 2 | Source addressing-mode field; selects the constant for index 2 and 3 |
| src_addr | input | 1 | Source read is address-size (sign-extends the all-ones constant) |
| src_rdata | output | XLEN | Source operand value |
| dst_idx | input | 4 | Destination index, used for both read and write |
| dst_rdata | output | XLEN | Current value of the destination register |
| wr_en | input | 1 | Write enable |
| wr_size | input | 2 | Operand size: 00 byte, 01 word, 10 address, 11 treated as word |
| wr_data | input | XLEN | Write data |

## Verification
The hardest case to reach is a constant read through index 2 while the status word holds a nonzero value that could leak into the result. The same applies to index 3 after a write has been aimed at it. The stimulus first loads the status word with wide, odd data and issues a write to index 3. It then sweeps every source index through all four modes and both read sizes, and after that runs a long random phase in which writes to indices 0 to 3 are as common as writes to the general registers. The reference model in the bench predicts both read ports before every clock edge, so any leakage shows up at once.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int NREG = 16;
  localparam int IDXW = $clog2(NREG);

  localparam logic [IDXW-1:0] IDX_PC = 4'd0;
  localparam logic [IDXW-1:0] IDX_SP = 4'd1;
  localparam logic [IDXW-1:0] IDX_SR = 4'd2;
  localparam logic [IDXW-1:0] IDX_CG = 4'd3;

  localparam int SR_W = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_ADDR = 2'b10,
    SZ_RSVD = 2'b11
  } wsize_e;
endpackage

// File: rtl/regbank_wfmt.sv
// Shapes write data by operand size and by the target register's rules.
module regbank_wfmt
  import regbank_pkg::*;
#(
  parameter int XLEN = 20
) (
  input  logic [IDXW-1:0] idx,
  input  logic [1:0]      size,
  input  logic [XLEN-1:0] data,
  output logic [XLEN-1:0] val
);
  localparam logic [XLEN-1:0] SR_MASK = XLEN'({SR_W{1'b1}});

  logic [XLEN-1:0] sized;

  always_comb begin
    unique case (wsize_e'(size))
      SZ_BYTE: sized = XLEN'(data[7:0]);
      SZ_ADDR: sized = data;
      default: sized = XLEN'(data[15:0]);
    endcase
  end

  always_comb begin
    val = sized;
    if (idx == IDX_SR) val = sized & SR_MASK;
    if (idx == IDX_PC || idx == IDX_SP) val[0] = 1'b0;
  end
endmodule

// File: rtl/regbank_cgen.sv
// Fixed constants served through source indices 2 (nonzero mode) and 3.
module regbank_cgen
  import regbank_pkg::*;
#(
  parameter int XLEN = 20
) (
  input  logic [IDXW-1:0] idx,
  input  logic [1:0]      mode,
  input  logic            addr_sz,
  output logic            hit,
  output logic [XLEN-1:0] val
);
  logic [XLEN-1:0] minus_one;

  generate
    if (XLEN > 16) begin : g_wide
      assign minus_one = addr_sz ? {XLEN{1'b1}} : XLEN'(16'hFFFF);
    end else begin : g_narrow
      logic unused_addr;
      assign unused_addr = addr_sz;
      assign minus_one   = {XLEN{1'b1}};
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    val = '0;
    if (idx == IDX_SR) begin
      hit = (mode != 2'b00);
      unique case (mode)
        2'b10:   val = XLEN'(4);
        2'b11:   val = XLEN'(8);
        default: val = '0;
      endcase
    end else if (idx == IDX_CG) begin
      hit = 1'b1;
      unique case (mode)
        2'b00:   val = '0;
        2'b01:   val = XLEN'(1);
        2'b10:   val = XLEN'(2);
        default: val = minus_one;
      endcase
    end
  end
endmodule

// File: rtl/regbank_store.sv
// Storage array: one synchronous write port, two combinational read ports.
module regbank_store
  import regbank_pkg::*;
#(
  parameter int XLEN = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_val,
  input  logic [IDXW-1:0] ra_idx,
  output logic [XLEN-1:0] ra_data,
  input  logic [IDXW-1:0] rb_idx,
  output logic [XLEN-1:0] rb_data
);
  logic [NREG-1:0][XLEN-1:0] regs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= '0;
    end else if (wr_en && wr_idx != IDX_CG) begin
      regs_q[wr_idx] <= wr_val;
    end
  end

  assign ra_data = regs_q[ra_idx];
  assign rb_data = regs_q[rb_idx];

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != IDX_CG) |=> regs_q[$past(wr_idx)] == $past(wr_val)); // R13

  AST_CG_EMPTY: assert property (@(posedge clk) disable iff (rst)
    regs_q[IDX_CG] == '0); // R11
endmodule

// File: rtl/regbank_cg.sv
module regbank_cg
  import regbank_pkg::*;
#(
  parameter int XLEN = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      src_idx,
  input  logic [1:0]      src_mode,
  input  logic            src_addr,
  output logic [XLEN-1:0] src_rdata,
  input  logic [3:0]      dst_idx,
  output logic [XLEN-1:0] dst_rdata,
  input  logic            wr_en,
  input  logic [1:0]      wr_size,
  input  logic [XLEN-1:0] wr_data
);
  localparam logic [XLEN-1:0] SR_MASK = XLEN'({SR_W{1'b1}});

  logic [XLEN-1:0] wr_val;
  logic [XLEN-1:0] ra_data;
  logic            cg_hit;
  logic [XLEN-1:0] cg_val;

  regbank_wfmt #(.XLEN(XLEN)) u_wfmt (
    .idx  (dst_idx),
    .size (wr_size),
    .data (wr_data),
    .val  (wr_val)
  );

  regbank_store #(.XLEN(XLEN)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (dst_idx),
    .wr_val  (wr_val),
    .ra_idx  (src_idx),
    .ra_data (ra_data),
    .rb_idx  (dst_idx),
    .rb_data (dst_rdata)
  );

  regbank_cgen #(.XLEN(XLEN)) u_cgen (
    .idx     (src_idx),
    .mode    (src_mode),
    .addr_sz (src_addr),
    .hit     (cg_hit),
    .val     (cg_val)
  );

  assign src_rdata = cg_hit ? cg_val : ra_data;

  AST_PC_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (dst_idx == IDX_PC || dst_idx == IDX_SP) |-> !dst_rdata[0]); // R12

  AST_SR_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (dst_idx == IDX_SR) |-> ((dst_rdata & ~SR_MASK) == '0)); // R10

  AST_CONST_STABLE: assert property (@(posedge clk) disable iff (rst)
    (src_idx == IDX_CG && $stable(src_idx) && $stable(src_mode) && $stable(src_addr))
      |-> $stable(src_rdata)); // R11

  AST_RST_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (dst_rdata == '0)); // R1
endmodule

// File: tb/sim_regbank_cg.sv
module sim_regbank_cg;
  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   src_idx = '0;
  logic [1:0]   src_mode = '0;
  logic         src_addr = 1'b0;
  logic [W-1:0] src_rdata;
  logic [3:0]   dst_idx = '0;
  logic [W-1:0] dst_rdata;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_size = '0;
  logic [W-1:0] wr_data = '0;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] mdl [16];

  always #2 clk = ~clk;

  regbank_cg #(.XLEN(W)) u0 (
    .clk, .rst, .src_idx, .src_mode, .src_addr, .src_rdata,
    .dst_idx, .dst_rdata, .wr_en, .wr_size, .wr_data
  );

  function automatic logic [W-1:0] exp_src(int i, int m, bit a);
    if (i == 2) begin
      if (m == 0) return mdl[2];
      if (m == 1) return 20'h0;
      if (m == 2) return 20'h4;
      return 20'h8;
    end
    if (i == 3) begin
      if (m == 0) return 20'h0;
      if (m == 1) return 20'h1;
      if (m == 2) return 20'h2;
      return a ? 20'hFFFFF : 20'h0FFFF;
    end
    return mdl[i];
  endfunction

  function automatic string src_tag(int i, int m, bit a);
    if (i == 2) return (m == 0) ? "R2" : "R3";
    if (i == 3) return (m == 3 && a) ? "R5" : "R4";
    return "R6";
  endfunction

  function automatic logic [W-1:0] stored(int i, int sz, logic [W-1:0] d);
    logic [W-1:0] v;
    if (sz == 0)      v = {12'h000, d[7:0]};
    else if (sz == 2) v = d;
    else              v = {4'h0, d[15:0]};
    if (i == 2) v = {4'h0, v[15:0]};
    if (i == 0 || i == 1) v = {v[W-1:1], 1'b0};
    return v;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive, compare both read ports before the edge, update model.
  task automatic cyc(int si, int sm, bit sa, int di, bit we, int sz,
                     logic [W-1:0] d, string dtag);
    src_idx = 4'(si); src_mode = 2'(sm); src_addr = sa;
    dst_idx = 4'(di); wr_en = we; wr_size = 2'(sz); wr_data = d;
    #1;
    check(src_tag(si, sm, sa), src_rdata, exp_src(si, sm, sa));
    check(dtag, dst_rdata, (di == 3) ? 20'h0 : mdl[di]);
    @(posedge clk);
    if (we && di != 3) mdl[di] = stored(di, sz, d);
    @(negedge clk);
  endtask

  task automatic rd(int di, string dtag);
    cyc(4, 0, 0, di, 0, 0, 20'h0, dtag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: everything cleared after reset
    for (int i = 0; i < 16; i++) begin
      dst_idx = 4'(i); #1;
      check("R1", dst_rdata, 20'h0);
      #0;
    end

    // load every register with distinct word data (R8)
    for (int i = 0; i < 16; i++)
      cyc(3, i % 4, 0, i, 1, 1, 20'(32'h5A30 + i * 32'h1111), "R8");
    for (int i = 0; i < 16; i++) rd(i, "R8");

    // R7 byte write clears upper bits
    cyc(0, 0, 0, 5, 1, 0, 20'hABCDE, "R7");
    rd(5, "R7");
    check("R7", dst_rdata, 20'h000DE);
    // R8 word and reserved size
    cyc(0, 0, 0, 6, 1, 1, 20'hABCDE, "R8");
    cyc(0, 0, 0, 8, 1, 3, 20'h9F00F, "R8");
    rd(6, "R8"); check("R8", dst_rdata, 20'h0BCDE);
    rd(8, "R8"); check("R8", dst_rdata, 20'h0F00F);
    // R9 full width
    cyc(0, 0, 0, 7, 1, 2, 20'hABCDE, "R9");
    rd(7, "R9"); check("R9", dst_rdata, 20'hABCDE);
    // R10 SR stays 16 bits
    cyc(0, 0, 0, 2, 1, 2, 20'hFFFFF, "R10");
    rd(2, "R10"); check("R10", dst_rdata, 20'h0FFFF);
    // R2/R3 with a loaded status word
    for (int m = 0; m < 4; m++) cyc(2, m, 0, 2, 0, 0, 20'h0, "R10");
    // R11 writes to index 3 ignored
    cyc(0, 0, 0, 3, 1, 2, 20'h12345, "R11");
    rd(3, "R11"); check("R11", dst_rdata, 20'h0);
    for (int m = 0; m < 4; m++) begin
      cyc(3, m, 0, 3, 0, 0, 20'h0, "R11");
      cyc(3, m, 1, 3, 0, 0, 20'h0, "R11");
    end
    // R12 PC / SP alignment
    cyc(0, 0, 0, 0, 1, 2, 20'h3FFFF, "R12");
    cyc(0, 0, 0, 1, 1, 1, 20'h01235, "R12");
    rd(0, "R12"); check("R12", dst_rdata, 20'h3FFFE);
    rd(1, "R12"); check("R12", dst_rdata, 20'h01234);
    // R13 same-cycle read sees old value, next cycle sees new
    cyc(9, 0, 0, 9, 1, 2, 20'h76543, "R13");
    check("R13", src_rdata, 20'h76543);
    rd(9, "R13");

    // exhaustive source sweep
    for (int i = 0; i < 16; i++)
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 2; a++)
          cyc(i, m, a[0], i, 0, 0, 20'h0, "R6");

    // random traffic, biased toward the special indices
    for (int n = 0; n < 4000; n++) begin
      int di;
      di = ($urandom % 3 == 0) ? int'($urandom % 4) : int'($urandom % 16);
      cyc(int'($urandom % 16), int'($urandom % 4), 1'($urandom),
          di, 1'($urandom), int'($urandom % 4), 20'($urandom), "R13");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule